// File: doc/BRIEF.md
# Fractional-N divider word calculator

This block turns a requested oscillator frequency into the control words a fractional-N synthesizer needs. The request is first limited to the supported range of 1.0 GHz to 3.5 GHz. The feedback path runs at twice a 19.2 MHz reference. From that the block derives three things: an integer divide word with an 18-bit fraction, a proportional loop-gain code and a clock-inverter code. It can also produce a spread-spectrum modulation period and a step size.

A caller presents the frequency and the spread settings, then pulses `start`. The block captures every input on that edge and runs a series of shift-subtract divisions, one quotient bit per clock. When it finishes it pulses `done` for one cycle. The result words change only on that cycle and hold their values until the next calculation completes. The caller must keep the spread frequency nonzero and the adjustment count below the resulting period whenever spread is enabled.

Top module: `frac_n_word_calc`

## Requirements
- R1: The frequency used for every result is the request limited to the range 1,000,000,000 to 3,500,000,000 Hz. A request below the range is raised to the minimum and one above it is lowered to the maximum.
- R2: With q = floor(fc * 2^18 / 38,400,000), where fc is the limited frequency, `int_word` is bits 25:18 of q. `frac_lo` is bits 7:0, `frac_mid` is bits 15:8 and `frac_hi` is bits 17:16.
- R3: `gain_code` is 8 when fc <= 1,900,000,000. It is 10 when fc <= 3,000,000,000, and 12 above that.
- R4: `inv_code` is 8 when fc < 1,100,000,000 and 0 otherwise.
- R5: With spread enabled, let r = floor((19,200,000 + floor(sf/2)) / sf) and p0 = floor(r/2) - 1. Then `ssc_period` is the low 16 bits of p0 - ((p0 + 1) mod (adj + 1)).
- R6: With spread enabled and p the period of R5, `ssc_step` is the low 16 bits of floor((floor(q * off * (adj + 1) / (p + 1)) + 500,000) / 1,000,000).
- R7: With spread disabled, `ssc_period` and `ssc_step` are 0.
- R8: A `start` seen while idle is accepted on that edge, and `busy` is 1 from the next cycle. Counting that edge as edge 0, `done` is 1 for exactly one cycle after edge 65 (no spread) or edge 325 (spread), and `busy` is 0 in that cycle.
- R9: While `busy` is 1, `start` and all data inputs are ignored. Results depend only on the values captured at the accepting edge.
- R10: After reset, `busy`, `done` and all result outputs are 0. Result outputs change only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation when idle |
| freq_hz | input | 32 | Requested oscillator frequency in Hz |
| ssc_en | input | 1 | Enable spread-spectrum word calculation |
| ssc_freq | input | 16 | Spread modulation frequency in Hz |
| ssc_offset | input | 16 | Spread depth, ppm-scaled |
| ssc_adj | input | 16 | Period alignment count |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| int_word | output | 8 | Integer divide word |
| frac_lo | output | 8 | Fraction bits 7:0 |
| frac_mid | output | 8 | Fraction bits 15:8 |
| frac_hi | output | 2 | Fraction bits 17:16 |
| gain_code | output | 4 | Proportional gain code |
| inv_code | output | 4 | Clock-inverter code |
| ssc_period | output | 16 | Spread period word |
| ssc_step | output | 16 | Spread step-size word |

## Verification
The main calculation is tried with requests below, inside and above the allowed range. A mismatch in those cases separates a missing limit from an error in the divide-word arithmetic. Requests sit exactly on and one hertz past each gain and inverter threshold, which exposes an inclusive-versus-exclusive comparison. Spread cases use the default settings and a second set with other frequency, depth and alignment values. They show whether rounding and period alignment are applied, and a run whose inputs are disturbed mid-calculation shows whether capture happens only at the accepting edge.

// File: rtl/frac_n_word_calc.sv
module frac_n_word_calc #(
  parameter int FW = 32,
  parameter int SW = 16,
  parameter int DW = 64,
  parameter int FRAC_BITS = 18,
  parameter logic [FW-1:0] REF_HZ = 32'd19_200_000,
  parameter logic [FW-1:0] F_MIN = 32'd1_000_000_000,
  parameter logic [FW-1:0] F_MAX = 32'd3_500_000_000,
  parameter logic [FW-1:0] GAIN_LO_MAX = 32'd1_900_000_000,
  parameter logic [FW-1:0] GAIN_MID_MAX = 32'd3_000_000_000,
  parameter logic [FW-1:0] INV_BELOW = 32'd1_100_000_000,
  parameter logic [DW-1:0] STEP_SCALE = 64'd1_000_000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [FW-1:0]          freq_hz,
  input  logic                   ssc_en,
  input  logic [SW-1:0]          ssc_freq,
  input  logic [SW-1:0]          ssc_offset,
  input  logic [SW-1:0]          ssc_adj,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             int_word,
  output logic [7:0]             frac_lo,
  output logic [7:0]             frac_mid,
  output logic [FRAC_BITS-17:0]  frac_hi,
  output logic [3:0]             gain_code,
  output logic [3:0]             inv_code,
  output logic [SW-1:0]          ssc_period,
  output logic [SW-1:0]          ssc_step
);

  localparam int QW = FRAC_BITS + 8;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_NEXT} st_t;

  st_t            st;
  logic [2:0]     ph;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  quo, rem, dvs, per;
  logic [FW-1:0]  fc;
  logic           en_q;
  logic [SW-1:0]  sf_q, off_q, adj_q;
  logic [QW-1:0]  qword;

  logic [DW:0]    trial, diff;
  logic           fits;
  logic [FW-1:0]  fin_c;
  logic [QW-1:0]  qsel;
  logic [3:0]     gain_w, inv_w;
  logic [DW-1:0]  prod;
  logic           finish;

  assign busy   = (st != S_IDLE);
  assign trial  = {rem, quo[DW-1]};
  assign diff   = trial - {1'b0, dvs};
  assign fits   = trial >= {1'b0, dvs};
  assign fin_c  = (freq_hz < F_MIN) ? F_MIN : ((freq_hz > F_MAX) ? F_MAX : freq_hz);
  assign qsel   = (ph == 3'd0) ? quo[QW-1:0] : qword;
  assign gain_w = (fc <= GAIN_LO_MAX) ? 4'd8 : ((fc <= GAIN_MID_MAX) ? 4'd10 : 4'd12);
  assign inv_w  = (fc < INV_BELOW) ? 4'd8 : 4'd0;
  assign prod   = DW'(qword) * DW'(off_q) * (DW'(adj_q) + DW'(1));
  assign finish = (st == S_NEXT) && ((ph == 3'd0 && !en_q) || ph == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; cnt <= '0;
      quo <= '0; rem <= '0; dvs <= '0; per <= '0;
      fc <= '0; en_q <= 1'b0; sf_q <= '0; off_q <= '0; adj_q <= '0; qword <= '0;
      done <= 1'b0;
      int_word <= '0; frac_lo <= '0; frac_mid <= '0; frac_hi <= '0;
      gain_code <= '0; inv_code <= '0; ssc_period <= '0; ssc_step <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fc <= fin_c; en_q <= ssc_en;
          sf_q <= ssc_freq; off_q <= ssc_offset; adj_q <= ssc_adj;
          quo <= DW'(fin_c) << FRAC_BITS;
          dvs <= DW'(REF_HZ) << 1;
          rem <= '0; cnt <= '0; ph <= '0;
          st <= S_DIV;
        end
        S_DIV: begin
          quo <= {quo[DW-2:0], fits};
          rem <= fits ? diff[DW-1:0] : trial[DW-1:0];
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) st <= S_NEXT;
        end
        default: begin
          rem <= '0; cnt <= '0; ph <= ph + 3'd1; st <= S_DIV;
          case (ph)
            3'd0: begin
              qword <= quo[QW-1:0];
              quo <= DW'(REF_HZ) + DW'(sf_q >> 1);
              dvs <= DW'(sf_q);
            end
            3'd1: begin
              per <= (quo >> 1) - DW'(1);
              quo <= quo >> 1;
              dvs <= DW'(adj_q) + DW'(1);
            end
            3'd2: begin
              per <= per - rem;
              quo <= prod;
              dvs <= per - rem + DW'(1);
            end
            3'd3: begin
              quo <= quo + (STEP_SCALE >> 1);
              dvs <= STEP_SCALE;
            end
            default: ;
          endcase
          if (finish) begin
            st <= S_IDLE;
            ph <= '0;
            done <= 1'b1;
            int_word  <= qsel[QW-1:FRAC_BITS];
            frac_lo   <= qsel[7:0];
            frac_mid  <= qsel[15:8];
            frac_hi   <= qsel[FRAC_BITS-1:16];
            gain_code <= gain_w;
            inv_code  <= inv_w;
            ssc_period <= en_q ? per[SW-1:0] : '0;
            ssc_step   <= en_q ? quo[SW-1:0] : '0;
          end
        end
      endcase
    end
  end

  assert_fc_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fc >= F_MIN && fc <= F_MAX));

  assert_inv_implies_low_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inv_code == 4'd0 || gain_code == 4'd8));

  assert_spread_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !en_q) |-> (ssc_period == '0 && ssc_step == '0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && $past(busy)) |-> $stable(fc));

  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({int_word, frac_lo, frac_mid, frac_hi, gain_code, inv_code, ssc_period, ssc_step}));

endmodule

// File: tb/tb_frac_n_word_calc.sv
module tb_frac_n_word_calc;
  localparam int CLK_PERIOD = 10;
  localparam int DIVW = 64;
  localparam int N_PLAIN = DIVW + 1;
  localparam int N_SSC = 5 * (DIVW + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ssc_en = 1'b0;
  logic [31:0] freq_hz = '0;
  logic [15:0] ssc_freq = '0, ssc_offset = '0, ssc_adj = '0;
  logic busy, done;
  logic [7:0] int_word, frac_lo, frac_mid;
  logic [1:0] frac_hi;
  logic [3:0] gain_code, inv_code;
  logic [15:0] ssc_period, ssc_step;

  int checks = 0, fails = 0;
  bit finished = 0;

  longint unsigned e_int, e_lo, e_mid, e_hi, e_gain, e_inv, e_per, e_step;
  longint unsigned p_int, p_lo, p_mid, p_hi, p_gain, p_inv, p_per, p_step;

  frac_n_word_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_hz(freq_hz),
    .ssc_en(ssc_en), .ssc_freq(ssc_freq), .ssc_offset(ssc_offset), .ssc_adj(ssc_adj),
    .busy(busy), .done(done), .int_word(int_word), .frac_lo(frac_lo),
    .frac_mid(frac_mid), .frac_hi(frac_hi), .gain_code(gain_code), .inv_code(inv_code),
    .ssc_period(ssc_period), .ssc_step(ssc_step)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(input longint unsigned f, input bit en, input longint unsigned sf,
                       input longint unsigned off, input longint unsigned adj);
    longint unsigned fc, q, r, p0, p, s;
    fc = (f < 64'd1_000_000_000) ? 64'd1_000_000_000 :
         ((f > 64'd3_500_000_000) ? 64'd3_500_000_000 : f);
    q = (fc << 18) / 64'd38_400_000;
    e_int = (q >> 18) & 64'hFF;
    e_lo = q & 64'hFF; e_mid = (q >> 8) & 64'hFF; e_hi = (q >> 16) & 64'h3;
    e_gain = (fc <= 64'd1_900_000_000) ? 8 : ((fc <= 64'd3_000_000_000) ? 10 : 12);
    e_inv = (fc < 64'd1_100_000_000) ? 8 : 0;
    if (en) begin
      r = (64'd19_200_000 + sf / 2) / sf;
      p0 = r / 2 - 1;
      p = p0 - ((p0 + 1) % (adj + 1));
      s = ((q * off * (adj + 1)) / (p + 1) + 64'd500_000) / 64'd1_000_000;
      e_per = p & 64'hFFFF; e_step = s & 64'hFFFF;
    end else begin
      e_per = 0; e_step = 0;
    end
  endtask

  task automatic cmp_outs(input string req, input bit use_prev);
    chk(int_word == (use_prev ? p_int : e_int), use_prev ? "R10" : "R2", "int_word", int_word, use_prev ? p_int : e_int);
    chk(frac_lo == (use_prev ? p_lo : e_lo), use_prev ? "R10" : "R2", "frac_lo", frac_lo, use_prev ? p_lo : e_lo);
    chk(frac_mid == (use_prev ? p_mid : e_mid), use_prev ? "R10" : "R2", "frac_mid", frac_mid, use_prev ? p_mid : e_mid);
    chk(frac_hi == (use_prev ? p_hi : e_hi), use_prev ? "R10" : "R2", "frac_hi", frac_hi, use_prev ? p_hi : e_hi);
    chk(gain_code == (use_prev ? p_gain : e_gain), use_prev ? "R10" : "R3", "gain_code", gain_code, use_prev ? p_gain : e_gain);
    chk(inv_code == (use_prev ? p_inv : e_inv), use_prev ? "R10" : "R4", "inv_code", inv_code, use_prev ? p_inv : e_inv);
    chk(ssc_period == (use_prev ? p_per : e_per), use_prev ? "R10" : req, "ssc_period", ssc_period, use_prev ? p_per : e_per);
    chk(ssc_step == (use_prev ? p_step : e_step), use_prev ? "R10" : req, "ssc_step", ssc_step, use_prev ? p_step : e_step);
  endtask

  task automatic run_case(input longint unsigned f, input bit en, input int unsigned sf,
                          input int unsigned off, input int unsigned adj,
                          input bit disturb, input string req);
    int n;
    model(f, en, sf, off, adj);
    n = en ? N_SSC : N_PLAIN;
    @(negedge clk);
    freq_hz = f[31:0]; ssc_en = en; ssc_freq = sf[15:0];
    ssc_offset = off[15:0]; ssc_adj = adj[15:0]; start = 1'b1;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      chk(done == (k == n), "R8", "done timing", done, (k == n));
      chk(busy == (k < n), "R8", "busy", busy, (k < n));
      if (k < n) cmp_outs(req, 1'b1);
      else cmp_outs(req, 1'b0);
      if (k == 0) start = 1'b0;
      if (disturb && k == 3) begin
        start = 1'b1; freq_hz = 32'd3_200_000_000; ssc_en = ~en;
        ssc_freq = 16'd20000; ssc_offset = 16'd9000; ssc_adj = 16'd5;
      end
      if (disturb && k == 4) start = 1'b0;
    end
    p_int = e_int; p_lo = e_lo; p_mid = e_mid; p_hi = e_hi;
    p_gain = e_gain; p_inv = e_inv; p_per = e_per; p_step = e_step;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    cmp_outs(req, 1'b1);
  endtask

  initial begin
    p_int = 0; p_lo = 0; p_mid = 0; p_hi = 0; p_gain = 0; p_inv = 0; p_per = 0; p_step = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10", "reset busy", busy, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    cmp_outs("R10", 1'b1);

    run_case(64'd1_500_000_000, 0, 31500, 5000, 2, 0, "R7");
    run_case(64'd500_000_000,   0, 31500, 5000, 2, 0, "R1");
    run_case(64'd4_000_000_000, 0, 31500, 5000, 2, 0, "R1");
    run_case(64'd1_900_000_000, 0, 31500, 5000, 2, 0, "R3");
    run_case(64'd1_900_000_001, 0, 31500, 5000, 2, 0, "R3");
    run_case(64'd3_000_000_000, 0, 31500, 5000, 2, 0, "R3");
    run_case(64'd3_000_000_001, 0, 31500, 5000, 2, 0, "R3");
    run_case(64'd1_099_999_999, 0, 31500, 5000, 2, 0, "R4");
    run_case(64'd1_100_000_000, 0, 31500, 5000, 2, 0, "R4");
    run_case(64'd2_345_678_901, 0, 31500, 5000, 2, 0, "R2");
    run_case(64'd1_500_000_000, 1, 31500, 5000, 2, 0, "R5");
    run_case(64'd2_700_000_000, 1, 30000, 4000, 3, 0, "R6");
    run_case(64'd3_500_000_000, 1, 33000, 6000, 1, 0, "R6");
    run_case(64'd1_234_567_890, 0, 31500, 5000, 2, 1, "R9");
    run_case(64'd2_100_000_000, 1, 31500, 5000, 2, 1, "R9");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule